// File: doc/BRIEF.md
# Conditional Jump and Program Counter

This block produces the instruction address for a single-cycle processor core. Every clock edge it decides whether the current instruction transfers control. If it does, the program counter is loaded with the value held in the A register. Otherwise the counter advances by one.

The decision uses two things: the three condition-select bits of the current instruction, and the zero and negative flags from the ALU result of that same instruction. Each select bit enables one condition on the result: negative, zero or strictly positive. A jump happens when any enabled condition is true, and only when the instruction is a compute instruction. A constant-load instruction never jumps, whatever its low bits hold.

The counter is registered. Reset has the highest priority, then load, then increment.

Top module: `jump_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0 after that edge, even if a jump condition holds in the same cycle.
- R2: When `rst` is low and no jump is taken, `pc` becomes the old `pc` plus one after the edge.
- R3: Increment wraps: a `pc` of 16'hFFFF that is not reset and takes no jump becomes 16'h0000.
- R4: When `rst` is low and a jump is taken, `pc` becomes the value of `a_value` sampled at that edge.
- R5: `jbits[2]` set requests a jump when `alu_neg` is 1.
- R6: `jbits[1]` set requests a jump when `alu_zero` is 1.
- R7: `jbits[0]` set requests a jump when both `alu_neg` and `alu_zero` are 0, which means the result is positive.
- R8: For a compute instruction, `jbits` = 3'b000 never jumps and `jbits` = 3'b111 always jumps, whatever the flags are.
- R9: When `is_compute` is 0 (a constant-load instruction), no jump is taken for any `jbits` or flag values, and `pc` increments.
- R10: The jump is taken if any one of the requested conditions holds. The per-bit requests are ORed together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| is_compute | input | 1 | 1 for a compute instruction, 0 for a constant-load instruction |
| jbits | input | 3 | Condition select: bit 2 negative, bit 1 zero, bit 0 positive |
| alu_zero | input | 1 | ALU result equals zero |
| alu_neg | input | 1 | ALU result is negative |
| a_value | input | 16 | Current A register contents, used as the jump target |
| pc | output | 16 | Registered program counter |

## Verification
Two pairs of functions can fall in the same edge.

The first pair is reset and a taken jump. The bench raises `rst` in a cycle where `jbits` = 3'b111 and `a_value` is non-zero. The design is judged correct only if `pc` reads 0 afterwards, not the target.

The second pair is the counter wrap and the jump decision. The bench jumps to 16'hFFFF and then offers a not-taken instruction, expecting 0. It then jumps to 16'hFFFF again and offers a taken one, expecting the new target rather than a wrap.

Random cycles also mix reset, load and increment freely. Each result is compared against a reference next-address function written in the bench.

// File: rtl/jump_pc_pkg.sv
package jump_pc_pkg;
  // Width of the condition-select field
  localparam int unsigned JSEL_W = 3;
  // Bit positions inside the condition-select field
  localparam int unsigned JB_POS  = 0;
  localparam int unsigned JB_ZERO = 1;
  localparam int unsigned JB_NEG  = 2;

  typedef enum logic [1:0] {
    PC_RESET = 2'd0,
    PC_LOAD  = 2'd1,
    PC_INCR  = 2'd2,
    PC_HOLD  = 2'd3
  } pc_action_e;
endpackage

// File: rtl/jump_cond_eval.sv
module jump_cond_eval
  import jump_pc_pkg::*;
#(
  parameter int unsigned SEL_W = JSEL_W
) (
  input  logic             is_compute,
  input  logic [SEL_W-1:0] jbits,
  input  logic             alu_zero,
  input  logic             alu_neg,
  output logic             take
);
  logic [SEL_W-1:0] hit;
  logic             result_pos;

  assign result_pos = ~alu_zero & ~alu_neg;

  // One condition per select bit, each evaluated on its own
  for (genvar i = 0; i < SEL_W; i++) begin : g_cond
    if (i == JB_NEG) begin : g_neg
      assign hit[i] = jbits[i] & alu_neg;
    end else if (i == JB_ZERO) begin : g_zero
      assign hit[i] = jbits[i] & alu_zero;
    end else if (i == JB_POS) begin : g_pos
      assign hit[i] = jbits[i] & result_pos;
    end else begin : g_unused
      assign hit[i] = 1'b0;
    end
  end

  // Only compute instructions can branch
  assign take = is_compute & (|hit);
endmodule

// File: rtl/pc_counter.sv
module pc_counter
  import jump_pc_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         inc,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  pc_action_e act;

  always_comb begin
    if (rst)       act = PC_RESET;
    else if (load) act = PC_LOAD;
    else if (inc)  act = PC_INCR;
    else           act = PC_HOLD;
  end

  always_ff @(posedge clk) begin
    case (act)
      PC_RESET: q <= '0;
      PC_LOAD:  q <= din;
      PC_INCR:  q <= q + W'(1);
      default:  q <= q;
    endcase
  end
endmodule

// File: rtl/jump_pc_unit.sv
module jump_pc_unit
  import jump_pc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_compute,
  input  logic [JSEL_W-1:0] jbits,
  input  logic              alu_zero,
  input  logic              alu_neg,
  input  logic [ADDR_W-1:0] a_value,
  output logic [ADDR_W-1:0] pc
);
  logic take_w;

  jump_cond_eval #(.SEL_W(JSEL_W)) u_cond (
    .is_compute (is_compute),
    .jbits      (jbits),
    .alu_zero   (alu_zero),
    .alu_neg    (alu_neg),
    .take       (take_w)
  );

  // The taken decision drives load; its complement drives increment
  pc_counter #(.W(ADDR_W)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .load (take_w),
    .inc  (~take_w),
    .din  (a_value),
    .q    (pc)
  );
endmodule

// File: rtl/jump_pc_checker.sv
module jump_pc_checker #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         is_compute,
  input logic [2:0]   jbits,
  input logic         alu_zero,
  input logic         alu_neg,
  input logic [W-1:0] a_value,
  input logic [W-1:0] pc,
  input logic         take
);
  p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc == '0);

  p_incr_r2: assert property (@(posedge clk) disable iff (rst)
    !take |=> pc == W'($past(pc) + W'(1)));

  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (!take && pc == '1) |=> pc == '0);

  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    take |=> pc == $past(a_value));

  p_neg_r5: assert property (@(posedge clk) disable iff (rst)
    (is_compute && jbits[2] && alu_neg) |-> take);

  p_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (is_compute && jbits[1] && alu_zero) |-> take);

  p_pos_r7: assert property (@(posedge clk) disable iff (rst)
    (is_compute && jbits[0] && !alu_zero && !alu_neg) |-> take);

  p_never_r8: assert property (@(posedge clk) disable iff (rst)
    (jbits == 3'b000) |-> !take);

  p_always_r8: assert property (@(posedge clk) disable iff (rst)
    (is_compute && jbits == 3'b111) |-> take);

  p_const_load_r9: assert property (@(posedge clk) disable iff (rst)
    !is_compute |-> !take);
endmodule

bind jump_pc_unit jump_pc_checker #(.W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .is_compute (is_compute),
  .jbits      (jbits),
  .alu_zero   (alu_zero),
  .alu_neg    (alu_neg),
  .a_value    (a_value),
  .pc         (pc),
  .take       (take_w)
);

// File: tb/tb_jump_pc_unit.sv
module tb_jump_pc_unit;
  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         is_compute = 1'b0;
  logic [2:0]   jbits = 3'b000;
  logic         alu_zero = 1'b0;
  logic         alu_neg = 1'b0;
  logic [W-1:0] a_value = '0;
  logic [W-1:0] pc;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_pc;
  bit done = 1'b0;

  always #5 clk = ~clk;

  jump_pc_unit #(.ADDR_W(W)) dut (
    .clk(clk), .rst(rst), .is_compute(is_compute), .jbits(jbits),
    .alu_zero(alu_zero), .alu_neg(alu_neg), .a_value(a_value), .pc(pc)
  );

  function automatic bit ref_take(bit c, logic [2:0] j, bit z, bit n);
    bit r;
    r = 1'b0;
    if (j[2] && n) r = 1'b1;
    if (j[1] && z) r = 1'b1;
    if (j[0] && !z && !n) r = 1'b1;
    return c && r;
  endfunction

  function automatic logic [W-1:0] ref_next(logic [W-1:0] cur, bit r, bit c,
                                            logic [2:0] j, bit z, bit n,
                                            logic [W-1:0] a);
    if (r) return '0;
    if (ref_take(c, j, z, n)) return a;
    return cur + 1;
  endfunction

  task automatic check(string req, logic [W-1:0] exp);
    checks++;
    if (pc !== exp) begin
      errors++;
      $display("FAIL %s pc actual %h expected %h", req, pc, exp);
    end
  endtask

  // Apply one cycle of inputs, then sample after the edge
  task automatic step(string req, bit r, bit c, logic [2:0] j, bit z, bit n,
                      logic [W-1:0] a);
    @(negedge clk);
    rst = r; is_compute = c; jbits = j; alu_zero = z; alu_neg = n; a_value = a;
    exp_pc = ref_next(exp_pc, r, c, j, z, n, a);
    @(posedge clk);
    #1;
    check(req, exp_pc);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_pc = '0;
    // R1 reset state
    step("R1", 1, 0, 3'b000, 0, 0, 16'h0000);
    // R2 plain increments
    step("R2", 0, 1, 3'b000, 0, 0, 16'h1234);
    step("R2", 0, 1, 3'b000, 1, 0, 16'h1234);
    // R5 negative condition
    step("R5", 0, 1, 3'b100, 0, 1, 16'h0100);
    step("R5", 0, 1, 3'b100, 0, 0, 16'h0200);
    // R6 zero condition
    step("R6", 0, 1, 3'b010, 1, 0, 16'h0300);
    step("R6", 0, 1, 3'b010, 0, 1, 16'h0400);
    // R7 positive condition
    step("R7", 0, 1, 3'b001, 0, 0, 16'h0500);
    step("R7", 0, 1, 3'b001, 1, 0, 16'h0600);
    step("R7", 0, 1, 3'b001, 0, 1, 16'h0700);
    // R10 combined conditions: >= 0 taken on zero, not on negative
    step("R10", 0, 1, 3'b011, 1, 0, 16'h0800);
    step("R10", 0, 1, 3'b011, 0, 1, 16'h0900);
    step("R10", 0, 1, 3'b101, 0, 0, 16'h0A00);
    // R8 never and always
    step("R8", 0, 1, 3'b000, 0, 1, 16'h0B00);
    step("R8", 0, 1, 3'b111, 1, 0, 16'h0C00);
    step("R8", 0, 1, 3'b111, 0, 0, 16'h0D00);
    // R9 constant-load never jumps
    step("R9", 0, 0, 3'b111, 1, 1, 16'h0E00);
    step("R9", 0, 0, 3'b111, 0, 0, 16'h0F00);
    // R4 jump to a target, then R3 wrap
    step("R4", 0, 1, 3'b111, 0, 0, 16'hFFFF);
    step("R3", 0, 1, 3'b000, 0, 0, 16'h5555);
    step("R4", 0, 1, 3'b111, 0, 0, 16'hFFFF);
    step("R4", 0, 1, 3'b111, 0, 0, 16'hABCD);
    // R1 reset wins over a taken jump
    step("R1", 1, 1, 3'b111, 1, 1, 16'h7777);
    step("R2", 0, 1, 3'b000, 0, 0, 16'h7777);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      bit r, c, z, n, t;
      logic [2:0] j;
      logic [W-1:0] a;
      string tag;
      r = ($urandom % 20) == 0;
      c = ($urandom % 4) != 0;
      j = 3'($urandom);
      z = 1'($urandom);
      n = 1'($urandom);
      a = ($urandom % 8 == 0) ? 16'hFFFF : W'($urandom);
      t = ref_take(c, j, z, n);
      if (r) tag = "R1";
      else if (!c) tag = "R9";
      else if (t) tag = "R4";
      else tag = "R2";
      step(tag, r, c, j, z, n, a);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule